// File: doc/BRIEF.md
# Banked LFSR Program Counter

This unit holds the program counter of a small microcontroller whose sequential fetch order is produced by a shift-register sequence rather than a binary incrementer. The counter is split into a bank field at the top and an in-bank offset field at the bottom. Only the offset field moves on an ordinary advance, so straight-line code never leaves its bank. Code runs across a bank boundary only through an absolute jump, which loads the whole address at once.

Each advance shifts the offset one place toward bit 0. The bit entering at the top is the XNOR of the two lowest offset bits. Starting from zero, this visits every offset value except all ones before it returns to zero. All ones is a fixed point that can only be entered by a jump, and a status pin reports when the offset sits there. Reset, jump and advance are plain control strobes and are applied on the next rising clock edge. They are not a stream: there is no handshake and no back-pressure, and the counter accepts one command on every cycle.

Top module: `banked_lfsr_pc`

## Requirements
- R1: With `rst` high at a rising edge, `pc` becomes all zeros after that edge, whatever `adv` and `jmp` are.
- R2: On an advance (`adv`=1, `jmp`=0, `rst`=0), the offset field `pc[LOW_W-1:0]` becomes the old offset shifted right by one. The new bit `LOW_W-1` is 1 when old bits 1 and 0 are equal and 0 when they differ.
- R3: An advance never alters the bank field `pc[PC_W-1:LOW_W]`.
- R4: With `jmp`=1 and `rst`=0, `pc` equals `jmp_addr` after the edge, bank and offset together.
- R5: When `jmp` and `adv` are both high, the jump is taken and the advance is ignored.
- R6: With `rst`, `jmp` and `adv` all low, `pc` keeps its value.
- R7: With the default width of 7, advancing from offset 0 returns to offset 0 after exactly 127 advances and not earlier.
- R8: An offset of all ones stays all ones under advance.
- R9: `low_stuck` is 1 exactly when the current offset field is all ones.
- R10: Built with `LOW_W`=3, advancing from zero gives the offsets 000, 100, 110, 011, 101, 010, 001, then 000 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | Advance the offset field by one step |
| jmp | input | 1 | Load `jmp_addr` into the whole counter |
| jmp_addr | input | PC_W (10) | Absolute jump target |
| pc | output | PC_W (10) | Current program counter |
| low_stuck | output | 1 | Offset field is all ones (fixed point) |

## Verification
The hardest state to reach is the all-ones offset. No sequence of advances ever produces it, so the bench reaches it only by jumping straight to an address whose offset is all ones, and then keeps advancing to confirm that the offset stays there. The full-period check is a second difficult case: it needs a jump into a nonzero bank followed by 127 consecutive advances, with the bank and every intermediate offset watched along the way. A second instance built with a 3-bit offset is stepped against the short known sequence.

// File: rtl/banked_pc_pkg.sv
package banked_pc_pkg;

  typedef enum logic [1:0] {
    PC_HOLD  = 2'd0,
    PC_STEP  = 2'd1,
    PC_LOAD  = 2'd2,
    PC_CLEAR = 2'd3
  } pc_op_e;

endpackage

// File: rtl/pc_op_decode.sv
module pc_op_decode
  import banked_pc_pkg::*;
(
  input  logic   rst,
  input  logic   jmp,
  input  logic   adv,
  output pc_op_e op
);

  // Priority: reset over jump over advance over hold.
  always_comb begin
    if (rst)      op = PC_CLEAR;
    else if (jmp) op = PC_LOAD;
    else if (adv) op = PC_STEP;
    else          op = PC_HOLD;
  end

endmodule

// File: rtl/lfsr_low_step.sv
module lfsr_low_step #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);

  logic feed;

  assign feed = ~(cur[1] ^ cur[0]);

  generate
    if (W == 2) begin : g_two
      assign nxt = {feed, cur[1]};
    end else begin : g_wide
      assign nxt = {feed, cur[W-1:1]};
    end
  endgenerate

endmodule

// File: rtl/lockup_detect.sv
module lockup_detect #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] low,
  output logic         stuck
);

  assign stuck = (low == {W{1'b1}});

endmodule

// File: rtl/banked_lfsr_pc.sv
module banked_lfsr_pc
  import banked_pc_pkg::*;
#(
  parameter int unsigned LOW_W  = 7,
  parameter int unsigned BANK_W = 3,
  localparam int unsigned PC_W  = LOW_W + BANK_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            jmp,
  input  logic [PC_W-1:0] jmp_addr,
  output logic [PC_W-1:0] pc,
  output logic            low_stuck
);

  pc_op_e            op;
  logic [PC_W-1:0]   pc_q;
  logic [LOW_W-1:0]  low_nxt;
  logic [BANK_W-1:0] bank_cur;

  assign bank_cur = pc_q[PC_W-1:LOW_W];

  pc_op_decode u_dec (
    .rst (rst),
    .jmp (jmp),
    .adv (adv),
    .op  (op)
  );

  lfsr_low_step #(.W(LOW_W)) u_step (
    .cur (pc_q[LOW_W-1:0]),
    .nxt (low_nxt)
  );

  lockup_detect #(.W(LOW_W)) u_lock (
    .low   (pc_q[LOW_W-1:0]),
    .stuck (low_stuck)
  );

  always_ff @(posedge clk) begin
    unique case (op)
      PC_CLEAR: pc_q <= '0;
      PC_LOAD:  pc_q <= jmp_addr;
      PC_STEP:  pc_q <= {bank_cur, low_nxt};
      default:  pc_q <= pc_q;
    endcase
  end

  assign pc = pc_q;

endmodule

// File: rtl/banked_lfsr_pc_chk.sv
module banked_lfsr_pc_chk #(
  parameter int unsigned LOW_W  = 7,
  parameter int unsigned BANK_W = 3,
  localparam int unsigned PC_W  = LOW_W + BANK_W
) (
  input logic            clk,
  input logic            rst,
  input logic            adv,
  input logic            jmp,
  input logic [PC_W-1:0] jmp_addr,
  input logic [PC_W-1:0] pc,
  input logic            low_stuck
);

  logic step_only;
  assign step_only = adv && !jmp;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pc == '0));

  a_r2_shift_right: assert property (@(posedge clk) disable iff (rst)
    step_only |=> (pc[LOW_W-2:0] == $past(pc[LOW_W-1:1])));

  a_r3_bank_kept: assert property (@(posedge clk) disable iff (rst)
    step_only |=> (pc[PC_W-1:LOW_W] == $past(pc[PC_W-1:LOW_W])));

  a_r4_jump_loads: assert property (@(posedge clk) disable iff (rst)
    jmp |=> (pc == $past(jmp_addr)));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !jmp) |=> $stable(pc));

  a_r8_lockup_fixed: assert property (@(posedge clk) disable iff (rst)
    (step_only && (pc[LOW_W-1:0] == {LOW_W{1'b1}})) |=> (pc[LOW_W-1:0] == {LOW_W{1'b1}}));

  a_r9_stuck_flag: assert property (@(posedge clk) disable iff (rst)
    low_stuck == (pc[LOW_W-1:0] == {LOW_W{1'b1}}));

endmodule

bind banked_lfsr_pc banked_lfsr_pc_chk #(.LOW_W(LOW_W), .BANK_W(BANK_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .adv       (adv),
  .jmp       (jmp),
  .jmp_addr  (jmp_addr),
  .pc        (pc),
  .low_stuck (low_stuck)
);

// File: tb/banked_lfsr_pc_bench.sv
`timescale 1ns/1ps
module banked_lfsr_pc_bench;

  localparam int LW = 7;
  localparam int BW = 3;
  localparam int PW = LW + BW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv = 1'b0;
  logic jmp = 1'b0;
  logic [PW-1:0] jmp_addr = '0;
  logic [PW-1:0] pc;
  logic low_stuck;

  logic adv3 = 1'b0;
  logic [5:0] pc3;
  logic stuck3;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  logic [PW-1:0] exp_q[$];
  string         tag_q[$];
  logic [PW-1:0] model = '0;

  always #2 clk = ~clk;

  banked_lfsr_pc u_banked_lfsr_pc (
    .clk(clk), .rst(rst), .adv(adv), .jmp(jmp), .jmp_addr(jmp_addr),
    .pc(pc), .low_stuck(low_stuck)
  );

  banked_lfsr_pc #(.LOW_W(3), .BANK_W(3)) u_banked_lfsr_pc_w3 (
    .clk(clk), .rst(rst), .adv(adv3), .jmp(1'b0), .jmp_addr(6'd0),
    .pc(pc3), .low_stuck(stuck3)
  );

  function automatic logic [15:0] lfsr_ref(input logic [15:0] v, input int w);
    logic [15:0] r;
    logic nb;
    nb = ~(v[1] ^ v[0]);
    r = v >> 1;
    r[w-1] = nb;
    return r & ((16'd1 << w) - 16'd1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Driver: applies one command, waits for the edge, pushes the model result.
  task automatic drive(input logic r, input logic a, input logic j,
                       input logic [PW-1:0] addr, input string tag);
    logic [15:0] lo;
    rst = r; adv = a; jmp = j; jmp_addr = addr;
    @(posedge clk);
    #1;
    if (r) model = '0;
    else if (j) model = addr;
    else if (a) begin
      lo = lfsr_ref({9'd0, model[LW-1:0]}, LW);
      model = {model[PW-1:LW], lo[LW-1:0]};
    end
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares design output with the queued expectation.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [PW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, pc, e);
      check({t, "/R9"}, low_stuck, (e[LW-1:0] == {LW{1'b1}}));
    end
  end

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  localparam logic [2:0] W3_SEQ [0:7] = '{3'b000, 3'b100, 3'b110, 3'b011,
                                          3'b101, 3'b010, 3'b001, 3'b000};

  initial begin
    int period;
    // R1: reset state
    repeat (3) drive(1'b1, 1'b0, 1'b0, '0, "R1");
    check("R1 w3", pc3, 6'd0);
    // R2, R3: advance from zero in bank 0
    for (int i = 0; i < 10; i++) drive(1'b0, 1'b1, 1'b0, '0, "R2");
    // R6: hold
    repeat (3) drive(1'b0, 1'b0, 1'b0, 10'h3FF, "R6");
    // R4: jump to bank 5 offset 0
    drive(1'b0, 1'b0, 1'b1, {3'b101, 7'h00}, "R4");
    // R7 and R3: full period inside bank 5
    period = 0;
    for (int k = 1; k <= 127; k++) begin
      drive(1'b0, 1'b1, 1'b0, '0, "R3");
      check("R3 bank", pc[PW-1:LW], 3'b101);
      if (pc[LW-1:0] == '0 && period == 0) period = k;
    end
    check("R7 period", period, 127);
    // R5: jump wins over advance
    drive(1'b0, 1'b1, 1'b1, 10'h2AB, "R5");
    check("R5 direct", pc, 10'h2AB);
    // R2: steps from a mixed offset
    repeat (5) drive(1'b0, 1'b1, 1'b0, '0, "R2");
    // R8, R9: jump into all-ones offset, then advance
    drive(1'b0, 1'b0, 1'b1, {3'b010, 7'h7F}, "R9");
    check("R9 flag", low_stuck, 1'b1);
    repeat (3) drive(1'b0, 1'b1, 1'b0, '0, "R8");
    check("R8 stuck", pc, {3'b010, 7'h7F});
    // R4: leave the lockup by jumping
    drive(1'b0, 1'b0, 1'b1, 10'h155, "R4");
    // R1: reset overrides jump and advance
    drive(1'b1, 1'b1, 1'b1, 10'h3C1, "R1");
    check("R1 override", pc, 10'd0);
    drive(1'b0, 1'b0, 1'b0, '0, "R6");
    // R10: 3-bit build sequence
    adv3 = 1'b1;
    for (int i = 1; i < 8; i++) begin
      @(posedge clk);
      #1;
      check("R10 w3", pc3[2:0], W3_SEQ[i]);
      check("R10 w3 bank", pc3[5:3], 3'b000);
    end
    adv3 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule